// File: doc/BRIEF.md
# Saturating Double-and-Accumulate Unit

This unit is a 32-bit signed arithmetic stage. It doubles its second operand and then adds the doubled value to the first operand, or subtracts it from the first operand. Each of the two steps clamps its result to the signed 32-bit range. A caller presents both operands, an add/subtract select and a valid strobe. One clock later the unit returns the clamped result, an output-valid strobe and a per-operation saturation bit.

A sticky saturation bit gathers every saturation event since it was last cleared. It is set when either the doubling step or the add/subtract step clamps. It goes low only through a dedicated clear input or through reset. This lets a sequence of operations run and be checked once at the end for any loss of range.

Top module: `sdq_unit`

## Requirements
- R1: The second operand `opnd_b` is doubled first. If `opnd_b` lies at or above 0x40000000, or below 0xC0000000 (as signed values), the doubled value clamps to 0x7FFFFFFF or 0x80000000 respectively. Otherwise the doubled value is exactly 2*`opnd_b`.
- R2: With `op_sub` = 0 the result is `opnd_a` plus the doubled value, clamped to the signed 32-bit range.
- R3: With `op_sub` = 1 the result is `opnd_a` minus the doubled value, clamped to the signed 32-bit range.
- R4: Positive clamping yields exactly 0x7FFFFFFF and negative clamping yields exactly 0x80000000.
- R5: `sat_now` is 1 with a valid result exactly when the doubling step or the add/subtract step clamped. It is 0 whenever `out_valid` is 0.
- R6: `sat_sticky` is set on the same edge that presents a saturating result. It stays set until a clock edge with `sat_clr` = 1. When a clear and a saturating operation meet on one edge, the bit ends set.
- R7: `out_valid` follows `in_valid` by exactly one clock. On edges without `in_valid`, `result` keeps its previous value.
- R8: A synchronous active-high `rst` sets `result` to 0 and sets `out_valid`, `sat_now` and `sat_sticky` to 0.
- R9: With `opnd_b` = 0x80000000, `op_sub` = 1 and a non-negative `opnd_a`, the result is 0x7FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and select are taken on this edge |
| op_sub | input | 1 | 0 = add the doubled operand, 1 = subtract it |
| opnd_a | input | 32 | First operand, signed |
| opnd_b | input | 32 | Operand to be doubled, signed |
| sat_clr | input | 1 | Clears the sticky saturation bit |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| result | output | 32 | Clamped signed result |
| sat_now | output | 1 | This result saturated in either step |
| sat_sticky | output | 1 | Accumulated saturation since last clear |

## Verification
The hardest case to reach is a double clamp. Here the doubling already saturates and the second step must clamp again in the opposite direction, as when a most-negative operand is doubled and then subtracted. The boundary of the doubling step (0x3FFFFFFF against 0x40000000, 0xBFFFFFFF against 0xC0000000) is also rarely hit by uniform values. The stimulus therefore mixes directed cases at these edges with random operands drawn in part from bands around those boundaries and around the extremes. Clear pulses are placed both on idle edges and on edges that carry a saturating operation, so the set-wins rule is exercised.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

    localparam int DW = 32;

    typedef logic [DW-1:0] word_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    typedef struct packed {
        word_t val;
        logic  sat;
    } satw_t;

    typedef struct packed {
        op_e   op;
        word_t a;
        word_t b;
    } req_t;

    localparam word_t WORD_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam word_t WORD_MIN = {1'b1, {(DW-1){1'b0}}};

    // Clamp value chosen by the sign of the overflow direction
    function automatic word_t clamp_to(input logic negative);
        return negative ? WORD_MIN : WORD_MAX;
    endfunction

endpackage

// File: rtl/sdq_double.sv
module sdq_double
    import sdq_pkg::*;
(
    input  word_t b_in,
    output satw_t dbl_out
);
    localparam int MSB = DW - 1;

    logic overflow;

    // Shifting left loses range when the two top bits disagree
    assign overflow = b_in[MSB] ^ b_in[MSB-1];

    always_comb begin
        dbl_out.sat = overflow;
        if (overflow) begin
            dbl_out.val = clamp_to(b_in[MSB]);
        end else begin
            dbl_out.val = {b_in[MSB-1:0], 1'b0};
        end
    end
endmodule

// File: rtl/sdq_addsub.sv
module sdq_addsub
    import sdq_pkg::*;
(
    input  op_e   op,
    input  word_t a_in,
    input  word_t d_in,
    output satw_t res_out
);
    localparam int MSB = DW - 1;

    word_t raw;
    logic  same_sign;
    logic  overflow;

    always_comb begin
        same_sign = (a_in[MSB] == d_in[MSB]);
        if (op == OP_SUB) begin
            raw      = a_in - d_in;
            overflow = !same_sign && (raw[MSB] != a_in[MSB]);
        end else begin
            raw      = a_in + d_in;
            overflow = same_sign && (raw[MSB] != a_in[MSB]);
        end
        res_out.sat = overflow;
        res_out.val = overflow ? clamp_to(a_in[MSB]) : raw;
    end
endmodule

// File: rtl/sdq_sticky.sv
module sdq_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_en,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_en) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/sdq_unit.sv
module sdq_unit
    import sdq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        op_sub,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic        sat_clr,
    output logic        out_valid,
    output logic [31:0] result,
    output logic        sat_now,
    output logic        sat_sticky
);
    req_t  req;
    satw_t dbl;
    satw_t sum;
    logic  step_sat;

    always_comb begin
        req.op = op_sub ? OP_SUB : OP_ADD;
        req.a  = opnd_a;
        req.b  = opnd_b;
    end

    sdq_double u_double (
        .b_in    (req.b),
        .dbl_out (dbl)
    );

    sdq_addsub u_addsub (
        .op      (req.op),
        .a_in    (req.a),
        .d_in    (dbl.val),
        .res_out (sum)
    );

    assign step_sat = in_valid && (dbl.sat || sum.sat);

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            out_valid <= 1'b0;
            sat_now   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            sat_now   <= step_sat;
            if (in_valid) begin
                result <= sum.val;
            end
        end
    end

    sdq_sticky u_sticky (
        .clk    (clk),
        .rst    (rst),
        .set_en (step_sat),
        .clr    (sat_clr),
        .flag   (sat_sticky)
    );
endmodule

// File: rtl/sdq_unit_chk.sv
module sdq_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        op_sub,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic        sat_clr,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        sat_now,
    input logic        sat_sticky
);
    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R5
    sat_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        sat_now |-> out_valid);

    // R6
    sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_sticky && !sat_clr) |=> sat_sticky);

    // R6
    sticky_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_sticky) |-> sat_now);

    // R6
    sticky_covers_chk: assert property (@(posedge clk) disable iff (rst)
        sat_now |-> sat_sticky);

    // R9
    neg_min_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sub && opnd_b == 32'h8000_0000 && !opnd_a[31])
        |=> (result == 32'h7FFF_FFFF && sat_now));
endmodule

bind sdq_unit sdq_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_sub     (op_sub),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .sat_clr    (sat_clr),
    .out_valid  (out_valid),
    .result     (result),
    .sat_now    (sat_now),
    .sat_sticky (sat_sticky)
);

// File: tb/sdq_unit_tb.sv
module sdq_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        sat_clr = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        sat_now;
    logic        sat_sticky;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_result = '0;
    logic        exp_sticky = 1'b0;

    always #4 clk = ~clk;

    sdq_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .op_sub     (op_sub),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .sat_clr    (sat_clr),
        .out_valid  (out_valid),
        .result     (result),
        .sat_now    (sat_now),
        .sat_sticky (sat_sticky)
    );

    localparam longint LMAX = 64'sd2147483647;
    localparam longint LMIN = -64'sd2147483648;

    function automatic longint clampl(input longint v, output logic hit);
        hit = 1'b0;
        if (v > LMAX) begin hit = 1'b1; return LMAX; end
        if (v < LMIN) begin hit = 1'b1; return LMIN; end
        return v;
    endfunction

    // Reference: wide arithmetic with explicit clamps (R1, R2, R3, R4)
    function automatic logic [32:0] model(input logic sub, input logic [31:0] a,
                                          input logic [31:0] b);
        longint la, lb, d, r;
        logic h1, h2;
        la = longint'($signed(a));
        lb = longint'($signed(b));
        d  = clampl(2 * lb, h1);
        r  = sub ? la - d : la + d;
        r  = clampl(r, h2);
        return {h1 | h2, r[31:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic sub, input logic [31:0] a,
                        input logic [31:0] b, input logic clr);
        logic [32:0] m;
        @(negedge clk);
        in_valid = v; op_sub = sub; opnd_a = a; opnd_b = b; sat_clr = clr;
        m = model(sub, a, b);
        @(posedge clk);
        #1;
        if (v) exp_result = m[31:0];
        exp_sticky = (v && m[32]) ? 1'b1 : (clr ? 1'b0 : exp_sticky);
        check("R7 out_valid", {31'd0, out_valid}, {31'd0, v});
        check(v ? "R2/R3 result" : "R7 result hold", result, exp_result);
        check("R5 sat_now", {31'd0, sat_now}, {31'd0, v && m[32]});
        check("R6 sat_sticky", {31'd0, sat_sticky}, {31'd0, exp_sticky});
        in_valid = 1'b0; sat_clr = 1'b0;
    endtask

    function automatic logic [31:0] pick_val(input int unsigned sel);
        logic [31:0] r;
        r = $urandom;
        case (sel % 5)
            0: return r;
            1: return 32'h4000_0000 + (r % 5) - 2;
            2: return 32'hC000_0000 + (r % 5) - 2;
            3: return (r[0] ? 32'h7FFF_FFFF : 32'h8000_0000) ^ (r % 4);
            default: return r % 256;
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        in_valid = 1'b1; opnd_b = 32'h4000_0000; sat_clr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        in_valid = 1'b0;
        // R8 reset state
        check("R8 result", result, 32'd0);
        check("R8 out_valid", {31'd0, out_valid}, 32'd0);
        check("R8 sat_now", {31'd0, sat_now}, 32'd0);
        check("R8 sat_sticky", {31'd0, sat_sticky}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1 boundary of the doubling step
        step(1, 0, 32'd0, 32'h3FFF_FFFF, 0);
        check("R1 exact double", result, 32'h7FFF_FFFE);
        check("R6 sticky stays clear", {31'd0, sat_sticky}, 32'd0);
        step(1, 0, 32'd0, 32'h4000_0000, 0);
        check("R4 positive clamp", result, 32'h7FFF_FFFF);
        step(1, 0, 32'd0, 32'hC000_0000, 0);
        check("R1 exact negative double", result, 32'h8000_0000);
        step(1, 0, 32'd0, 32'hBFFF_FFFF, 0);
        check("R4 negative clamp", result, 32'h8000_0000);
        // R6 idle clear
        step(0, 0, 32'd0, 32'd0, 1);
        check("R6 cleared", {31'd0, sat_sticky}, 32'd0);
        // R2 sum overflow only
        step(1, 0, 32'h7FFF_FFF0, 32'h0000_0010, 0);
        check("R2 sum clamp", result, 32'h7FFF_FFFF);
        // R6 clear and set together: set wins
        step(1, 1, 32'h8000_0000, 32'h0000_0001, 1);
        check("R6 set wins", {31'd0, sat_sticky}, 32'd1);
        // R6 non-saturating ops keep the bit
        step(1, 1, 32'd100, 32'd7, 0);
        check("R3 plain difference", result, 32'd86);
        check("R6 sticky kept", {31'd0, sat_sticky}, 32'd1);
        // R9 double clamp corner
        step(0, 0, 32'd0, 32'd0, 1);
        step(1, 1, 32'd5, 32'h8000_0000, 0);
        check("R9 corner", result, 32'h7FFF_FFFF);
        step(1, 1, 32'd0, 32'h8000_0000, 0);
        check("R9 zero first operand", result, 32'h7FFF_FFFF);
        // R7 hold across idle cycles
        step(0, 1, 32'h1234_5678, 32'h1, 0);
        step(0, 0, 32'h0, 32'h2, 0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int unsigned ctl;
            ctl = $urandom;
            step(ctl % 7 != 0, ctl[3], pick_val($urandom), pick_val($urandom),
                 ctl[8:5] == 4'd0);
        end

        // R8 reset mid-run
        step(1, 0, 32'd0, 32'h4000_0000, 0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R8 result after reset", result, 32'd0);
        check("R8 sticky after reset", {31'd0, sat_sticky}, 32'd0);
        check("R8 out_valid after reset", {31'd0, out_valid}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule